// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the central sequencer of a small 16-bit processor that needs several clock cycles per instruction. It walks each instruction through a chain of phases (instruction fetch, decode, one of three compute phases, optional memory traffic, register update and program-counter update). It presents the current phase as a registered 4-bit code that every datapath unit watches to decide when it acts.

The path an instruction takes is chosen by four small control codes that the instruction decoder supplies during the decode and address phases. The codes are an instruction class, a flag that asks for the return address to be saved, a memory access mode and a load/store flag. Memory phases wait on a completion handshake from the memory, so slow memories simply stretch those phases.

A phase code that does not belong to any defined phase, or an instruction class the controller does not know, parks the controller in a trap phase. It stays there until reset.

Top module: `mcc_master_ctl`

## Requirements
- R1: Driving `rst_n` low puts `phase_o` at the fetch code 0 at once, without waiting for a clock edge, and it stays there while `rst_n` is low.
- R2: In the fetch (0), memory-read (5), memory-write (6) and pointer-read (7) phases, `phase_o` keeps its value on every clock edge where `mem_done` is 0.
- R3: Fetch moves to decode (1) on an edge with `mem_done` 1. Decode always lasts exactly one cycle.
- R4: From decode, `instr_class` 0 goes to ALU execute (2), class 1 goes to target compute (3) and class 2 goes to address compute (4).
- R5: From target compute, `save_link` 1 goes to register update (8) so the return address can be written to the link register, and `save_link` 0 goes to PC update (9).
- R6: From address compute, `access_mode` 0 goes to memory read, 1 to memory write, 2 to pointer read and 3 to register update (the effective-address path).
- R7: A pointer read that completes goes to memory read when `is_load` is 1 and to memory write when `is_load` is 0.
- R8: ALU execute, and a memory read that completes, go to register update. Register update, and a memory write that completes, go to PC update.
- R9: PC update always returns to fetch on the next edge.
- R10: `instr_class` 3 in decode enters the trap phase (15), as does any code from 10 to 14. The trap phase holds whatever the inputs do until reset.
- R11: `phase_o` only ever shows one of the codes 0 to 9 or 15. It is taken straight from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_done | input | 1 | Memory completion handshake |
| instr_class | input | 2 | Instruction class from the decoder |
| save_link | input | 1 | Save return address before the PC update |
| access_mode | input | 2 | Memory access mode from the decoder |
| is_load | input | 1 | Load (1) or store (0) after a pointer read |
| phase_o | output | 4 | Registered current phase code |

## Verification
The bench goes after the four wait phases with `mem_done` toggling at random. A design that ignored the handshake there would race ahead of memory, and one that waited in decode would add a cycle. It sweeps every access mode, including mode 3, which must skip memory entirely, and both outcomes of the pointer read. A swapped flag there would turn an indirect load into a store. It also drives class 3 and random inputs while in the trap phase, then applies reset in the middle of an instruction. A controller that fell back to fetch on its own would run on after an illegal instruction, and one with a synchronous reset would show a stale phase right after `rst_n` falls.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int unsigned PHASE_W = 4;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned MODE_W  = 2;

  typedef logic [PHASE_W-1:0] phase_t;

  // Fixed phase codes; the datapath decodes these values.
  localparam phase_t PH_FETCH  = 4'd0;
  localparam phase_t PH_DECODE = 4'd1;
  localparam phase_t PH_ALU    = 4'd2;
  localparam phase_t PH_TARGET = 4'd3;
  localparam phase_t PH_ADDR   = 4'd4;
  localparam phase_t PH_MEMRD  = 4'd5;
  localparam phase_t PH_MEMWR  = 4'd6;
  localparam phase_t PH_PTRRD  = 4'd7;
  localparam phase_t PH_REGWR  = 4'd8;
  localparam phase_t PH_PCUPD  = 4'd9;
  localparam phase_t PH_TRAP   = 4'd15;

  localparam logic [CLASS_W-1:0] CLS_ALU  = 2'd0;
  localparam logic [CLASS_W-1:0] CLS_FLOW = 2'd1;
  localparam logic [CLASS_W-1:0] CLS_MEM  = 2'd2;

  localparam logic [MODE_W-1:0] AM_READ  = 2'd0;
  localparam logic [MODE_W-1:0] AM_WRITE = 2'd1;
  localparam logic [MODE_W-1:0] AM_PTR   = 2'd2;
  localparam logic [MODE_W-1:0] AM_EA    = 2'd3;

endpackage

// File: rtl/mcc_route.sv
// Turns the decoder control codes into candidate successor phases for
// each branching point of the sequence.
module mcc_route
  import mcc_pkg::*;
(
  input  logic [CLASS_W-1:0] instr_class,
  input  logic               save_link,
  input  logic [MODE_W-1:0]  access_mode,
  input  logic               is_load,
  output phase_t             after_decode,
  output phase_t             after_target,
  output phase_t             after_addr,
  output phase_t             after_ptr
);

  always_comb begin
    unique case (instr_class)
      CLS_ALU:  after_decode = PH_ALU;
      CLS_FLOW: after_decode = PH_TARGET;
      CLS_MEM:  after_decode = PH_ADDR;
      default:  after_decode = PH_TRAP;
    endcase
  end

  always_comb begin
    after_target = save_link ? PH_REGWR : PH_PCUPD;
  end

  always_comb begin
    unique case (access_mode)
      AM_READ:  after_addr = PH_MEMRD;
      AM_WRITE: after_addr = PH_MEMWR;
      AM_PTR:   after_addr = PH_PTRRD;
      default:  after_addr = PH_REGWR;
    endcase
  end

  always_comb begin
    after_ptr = is_load ? PH_MEMRD : PH_MEMWR;
  end

endmodule

// File: rtl/mcc_next_phase.sv
// Next-phase logic: waits on the memory handshake and selects the routed
// successors at branching points.
module mcc_next_phase
  import mcc_pkg::*;
(
  input  phase_t cur,
  input  logic   mem_done,
  input  phase_t after_decode,
  input  phase_t after_target,
  input  phase_t after_addr,
  input  phase_t after_ptr,
  output phase_t nxt
);

  always_comb begin
    nxt = PH_TRAP;
    case (cur)
      PH_FETCH:  nxt = mem_done ? PH_DECODE : PH_FETCH;
      PH_DECODE: nxt = after_decode;
      PH_ALU:    nxt = PH_REGWR;
      PH_TARGET: nxt = after_target;
      PH_ADDR:   nxt = after_addr;
      PH_MEMRD:  nxt = mem_done ? PH_REGWR : PH_MEMRD;
      PH_MEMWR:  nxt = mem_done ? PH_PCUPD : PH_MEMWR;
      PH_PTRRD:  nxt = mem_done ? after_ptr : PH_PTRRD;
      PH_REGWR:  nxt = PH_PCUPD;
      PH_PCUPD:  nxt = PH_FETCH;
      default:   nxt = PH_TRAP;
    endcase
  end

endmodule

// File: rtl/mcc_phase_reg.sv
// Phase register with explicit load enable and asynchronous reset.
module mcc_phase_reg
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  phase_t d,
  output phase_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= PH_FETCH;
    end else if (load_en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/mcc_master_ctl.sv
module mcc_master_ctl
  import mcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_done,
  input  logic [CLASS_W-1:0] instr_class,
  input  logic               save_link,
  input  logic [MODE_W-1:0]  access_mode,
  input  logic               is_load,
  output logic [PHASE_W-1:0] phase_o
);

  phase_t cur_q;
  phase_t nxt_d;
  phase_t to_decode;
  phase_t to_target;
  phase_t to_addr;
  phase_t to_ptr;
  logic   phase_en;

  mcc_route u_route (
    .instr_class  (instr_class),
    .save_link    (save_link),
    .access_mode  (access_mode),
    .is_load      (is_load),
    .after_decode (to_decode),
    .after_target (to_target),
    .after_addr   (to_addr),
    .after_ptr    (to_ptr)
  );

  mcc_next_phase u_next (
    .cur          (cur_q),
    .mem_done     (mem_done),
    .after_decode (to_decode),
    .after_target (to_target),
    .after_addr   (to_addr),
    .after_ptr    (to_ptr),
    .nxt          (nxt_d)
  );

  // The register only loads when the phase actually changes.
  assign phase_en = (nxt_d != cur_q);

  mcc_phase_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (phase_en),
    .d       (nxt_d),
    .q       (cur_q)
  );

  assign phase_o = cur_q;

endmodule

// File: rtl/mcc_master_ctl_chk.sv
module mcc_master_ctl_chk
  import mcc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mem_done,
  input logic [CLASS_W-1:0] instr_class,
  input logic               save_link,
  input logic [MODE_W-1:0]  access_mode,
  input logic               is_load,
  input logic [PHASE_W-1:0] phase_o
);

  logic waiting;
  assign waiting = (phase_o == PH_FETCH) || (phase_o == PH_MEMRD) ||
                   (phase_o == PH_MEMWR) || (phase_o == PH_PTRRD);

  AST_RESET_FETCH: assert property (@(posedge clk) !rst_n |-> phase_o == PH_FETCH); // R1
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (waiting && !mem_done) |=> $stable(phase_o)); // R2
  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_FETCH && mem_done) |=> phase_o == PH_DECODE); // R3
  AST_DECODE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_DECODE) |=> phase_o != PH_DECODE); // R3
  AST_CLASS_ALU: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_DECODE && instr_class == 2'd0) |=> phase_o == PH_ALU); // R4
  AST_CLASS_FLOW: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_DECODE && instr_class == 2'd1) |=> phase_o == PH_TARGET); // R4
  AST_CLASS_MEM: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_DECODE && instr_class == 2'd2) |=> phase_o == PH_ADDR); // R4
  AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_TARGET && save_link) |=> phase_o == PH_REGWR); // R5
  AST_LINK_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_TARGET && !save_link) |=> phase_o == PH_PCUPD); // R5
  AST_MODE_READ: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_ADDR && access_mode == 2'd0) |=> phase_o == PH_MEMRD); // R6
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_ADDR && access_mode == 2'd1) |=> phase_o == PH_MEMWR); // R6
  AST_MODE_PTR: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_ADDR && access_mode == 2'd2) |=> phase_o == PH_PTRRD); // R6
  AST_MODE_EA: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_ADDR && access_mode == 2'd3) |=> phase_o == PH_REGWR); // R6
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_PTRRD && mem_done && is_load) |=> phase_o == PH_MEMRD); // R7
  AST_PTR_STORE: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_PTRRD && mem_done && !is_load) |=> phase_o == PH_MEMWR); // R7
  AST_JOIN_REGWR: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_ALU || (phase_o == PH_MEMRD && mem_done)) |=> phase_o == PH_REGWR); // R8
  AST_JOIN_PCUPD: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_REGWR || (phase_o == PH_MEMWR && mem_done)) |=> phase_o == PH_PCUPD); // R8
  AST_PC_RETURN: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_PCUPD) |=> phase_o == PH_FETCH); // R9
  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_DECODE && instr_class == 2'd3) |=> phase_o == PH_TRAP); // R10
  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (phase_o == PH_TRAP) |=> phase_o == PH_TRAP); // R10
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n) (phase_o <= 4'd9) || (phase_o == PH_TRAP)); // R11

endmodule

bind mcc_master_ctl mcc_master_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_done    (mem_done),
  .instr_class (instr_class),
  .save_link   (save_link),
  .access_mode (access_mode),
  .is_load     (is_load),
  .phase_o     (phase_o)
);

// File: tb/tb_mcc_master_ctl.sv
`timescale 1ns/1ps
module tb_mcc_master_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_done = 1'b0;
  logic [1:0] instr_class = 2'd0;
  logic       save_link = 1'b0;
  logic [1:0] access_mode = 2'd0;
  logic       is_load = 1'b0;
  logic [3:0] phase_o;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mcc_master_ctl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_done    (mem_done),
    .instr_class (instr_class),
    .save_link   (save_link),
    .access_mode (access_mode),
    .is_load     (is_load),
    .phase_o     (phase_o)
  );

  // Behavioural reference: phase numbers from the requirements.
  int    exp_phase;
  string exp_req;
  int    trap_cycles;

  function automatic int ref_step(input int p, input string tag_in, output string tag);
    tag = tag_in;
    if (p == 0) begin
      tag = mem_done ? "R3" : "R2";
      return mem_done ? 1 : 0;
    end else if (p == 1) begin
      tag = (instr_class == 3) ? "R10" : "R4";
      return (instr_class == 0) ? 2 : (instr_class == 1) ? 3 : (instr_class == 2) ? 4 : 15;
    end else if (p == 2) begin
      tag = "R8"; return 8;
    end else if (p == 3) begin
      tag = "R5"; return save_link ? 8 : 9;
    end else if (p == 4) begin
      tag = "R6";
      return (access_mode == 0) ? 5 : (access_mode == 1) ? 6 : (access_mode == 2) ? 7 : 8;
    end else if (p == 5) begin
      tag = mem_done ? "R8" : "R2"; return mem_done ? 8 : 5;
    end else if (p == 6) begin
      tag = mem_done ? "R8" : "R2"; return mem_done ? 9 : 6;
    end else if (p == 7) begin
      tag = mem_done ? "R7" : "R2";
      return mem_done ? (is_load ? 5 : 6) : 7;
    end else if (p == 8) begin
      tag = "R8"; return 9;
    end else if (p == 9) begin
      tag = "R9"; return 0;
    end
    tag = "R10";
    return 15;
  endfunction

  task automatic check_phase(input string req);
    checks++;
    if (int'(phase_o) != exp_phase) begin
      fails++;
      $display("FAIL %s: phase_o=%0d expected=%0d at %0t", req, phase_o, exp_phase, $time);
    end
    // R11: only defined codes may appear
    checks++;
    if (!(phase_o <= 4'd9 || phase_o == 4'd15)) begin
      fails++;
      $display("FAIL R11: phase_o=%0d expected a code in 0..9 or 15", phase_o);
    end
  endtask

  task automatic drive_random();
    int r;
    r = $urandom_range(0, 39);
    instr_class = (r == 0) ? 2'd3 : 2'($urandom_range(0, 2));
    mem_done    = 1'($urandom_range(0, 1));
    save_link   = 1'($urandom_range(0, 1));
    access_mode = 2'($urandom_range(0, 3));
    is_load     = 1'($urandom_range(0, 1));
  endtask

  task automatic step_model();
    string t;
    exp_phase = ref_step(exp_phase, exp_req, t);
    exp_req = t;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_phase = 0;
    #1;
    check_phase("R1"); // asynchronous: visible before any edge
    @(negedge clk);
    check_phase("R1");
    drive_random();
    rst_n = 1'b1;
    step_model();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    exp_phase = 0;
    exp_req = "R1";
    trap_cycles = 0;
    repeat (2) @(negedge clk);
    check_phase("R1");
    drive_random();
    rst_n = 1'b1;
    step_model();
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      check_phase(exp_req);
      if (exp_phase == 15) trap_cycles++;
      if (exp_phase == 15 && trap_cycles >= 6) begin
        // R10: trap held for six random cycles; leave only by reset
        trap_cycles = 0;
        apply_reset();
      end else if (cyc % 997 == 500) begin
        apply_reset(); // R1: reset in the middle of an instruction
      end else begin
        drive_random();
        step_model();
      end
    end
    @(negedge clk);
    check_phase(exp_req);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

endmodule